// File: doc/BRIEF.md
# Block-Copy DMA Engine with Interrupt Reporting

This engine moves a block of bytes from one memory region to another through one request/ready memory port. Software sets it up through a 32-bit register port. It writes a source address, a destination address, one configuration word for each side, a byte count and a direction flag. It then writes the start bit of the command register. The engine reads from the source in beats of the source width and writes to the destination in beats of the destination width. It packs the bytes through a holding register, so a side with 16-bit beats can feed a side with 32-bit beats, and the reverse.

The engine keeps two sticky flags, done and error. Each one is cleared by its own command bit. Both events also go to a small interrupt section. That section has pending, mask, masked-status and write-one-to-clear registers, and one level interrupt output. The direction flag and the burst-length field are stored and can be read back. Bytes are packed little-endian: the beat at the lowest address goes into the lowest byte lanes.

Top module: `dma_engine`

## Requirements
- R1: Register offsets are as follows. Source address 0x400, source config 0x404, destination address 0x408, destination config 0x40C, byte count 0x414, command 0x418, status 0x41C, direction 0x420 (bit 0 only). Interrupt clear 0x1004, interrupt mask 0x1024, interrupt pending 0x1044, interrupt masked status 0x1064. Address and count registers read back what was written. After reset, every register reads 0 except the mask, which reads 0x01010000.
- R2: Each config word keeps three fields: beat width in bits [1:0] (0 = 8-bit, 1 = 16-bit, 2 = 32-bit; 3 acts as 32-bit), fixed address in bit 8 (0 = increment, 1 = constant), and burst code in bits [18:16]. Only these bits read back.
- R3: After a start, the engine copies exactly the programmed number of bytes from source to destination. With 16-bit source beats and 32-bit destination beats, a 16-byte copy makes 8 reads and 4 writes.
- R4: With 32-bit source beats and 16-bit destination beats, a 12-byte copy makes 3 reads and 6 writes, and the data stays byte-exact.
- R5: On a side whose fixed-address bit is set, every beat uses the programmed address.
- R6: Writing command bit 0 starts a transfer. Status bit 17 (busy) is set from the cycle after the start write until the last write completes. Status bit 18 (done) then stays set until command bit 18 is written.
- R7: A byte count of zero sets done and makes no memory access.
- R8: An error response on the memory port ends the transfer at once and clears busy. It sets status bit 16 (error). Start commands are ignored until command bit 16 clears the error.
- R9: A start command written while busy is ignored.
- R10: Each done event sets pending bit 24 and each error event sets pending bit 16. Mask bits 24 and 16 block their interrupts when set. Masked status is pending AND NOT mask. The irq output is high when any masked-status bit is set.
- R11: Writing a 1 to bit 24 or bit 16 of the clear register clears that pending bit.
- R12: Once a memory request is raised, it holds its address and direction until mem_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 13 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | 32 | Beat byte address |
| mem_size | output | 2 | Beat width code (0 = 8-bit, 1 = 16-bit, 2 = 32-bit) |
| mem_wdata | output | 32 | Write data, low-lane aligned |
| mem_rdata | input | 32 | Read data, low-lane aligned |
| mem_ready | input | 1 | Beat complete |
| mem_err | input | 1 | Error response, valid with mem_ready |
| irq | output | 1 | Level interrupt |

## Verification
The hardest state to reach is an error that arrives in the middle of a copy, after some bytes have already been written. The engine must stop there, and the error must then block further starts. The bench memory model gives an error response on one chosen source address, two beats into a copy. The bench then checks how much data reached the destination, and that a following start leaves the beat counters unchanged. A start written while busy is forced by slowing the memory responses, so the transfer is still running when the second command arrives.

// File: rtl/dma_pkg.sv
// Shared types, register offsets and helpers for the block-copy DMA engine.
// Assumes byte addressing and beat widths of at most 32 bits.
package dma_pkg;
    localparam int OFF_SRC_ADDR  = 'h400;
    localparam int OFF_SRC_CFG   = 'h404;
    localparam int OFF_DST_ADDR  = 'h408;
    localparam int OFF_DST_CFG   = 'h40C;
    localparam int OFF_SIZE      = 'h414;
    localparam int OFF_CMD       = 'h418;
    localparam int OFF_STATUS    = 'h41C;
    localparam int OFF_DIR       = 'h420;
    localparam int OFF_IRQ_CLR   = 'h1004;
    localparam int OFF_IRQ_MASK  = 'h1024;
    localparam int OFF_IRQ_PEND  = 'h1044;
    localparam int OFF_IRQ_STAT  = 'h1064;

    typedef struct packed {
        logic [2:0] burst;
        logic       fixed;
        logic [1:0] width;
    } side_cfg_t;

    typedef enum logic [1:0] {MV_IDLE, MV_READ, MV_WRITE} mv_state_t;

    // Bytes per beat for a width code; code 3 is treated as 32-bit.
    function automatic logic [2:0] beat_bytes(input logic [1:0] w);
        case (w)
            2'd0:    beat_bytes = 3'd1;
            2'd1:    beat_bytes = 3'd2;
            default: beat_bytes = 3'd4;
        endcase
    endfunction
endpackage

// File: rtl/dma_irq_ctl.sv
// Interrupt section: latches done and error events into pending bits,
// applies the mask (set = blocked) and drives one level interrupt.
// Assumes event pulses last one cycle; a set wins over a clear in the same cycle.
module dma_irq_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic done_evt,
    input  logic err_evt,
    input  logic clr_done,
    input  logic clr_err,
    input  logic mask_we,
    input  logic mask_done_in,
    input  logic mask_err_in,
    output logic pend_done,
    output logic pend_err,
    output logic mask_done,
    output logic mask_err,
    output logic irq
);
    // Pending bits: set by events, cleared by write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_done <= 1'b0;
            pend_err  <= 1'b0;
        end else begin
            if (done_evt)      pend_done <= 1'b1;
            else if (clr_done) pend_done <= 1'b0;
            if (err_evt)       pend_err  <= 1'b1;
            else if (clr_err)  pend_err  <= 1'b0;
        end
    end

    // Mask bits: both interrupts blocked after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_done <= 1'b1;
            mask_err  <= 1'b1;
        end else if (mask_we) begin
            mask_done <= mask_done_in;
            mask_err  <= mask_err_in;
        end
    end

    // Level interrupt from unmasked pending bits.
    always_comb irq = (pend_done && !mask_done) || (pend_err && !mask_err);

    assert_pend_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_done) |-> $past(done_evt));
    assert_err_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_err) |-> $past(err_evt));
    assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_done && !done_evt) |=> !pend_done);
endmodule

// File: rtl/dma_mover.sv
// Transfer sequencer: for each unit of the wider beat width it reads source
// beats into a holding register, then drains it as destination beats.
// Assumes the byte count is a multiple of the wider width; the side
// settings are captured at start.
module dma_mover
    import dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] src_addr,
    input  logic [AW-1:0] dst_addr,
    input  logic [1:0]    src_width,
    input  logic          src_fixed,
    input  logic [1:0]    dst_width,
    input  logic          dst_fixed,
    input  logic [SW-1:0] size,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_size,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    input  logic          mem_ready,
    input  logic          mem_err,
    output logic          busy,
    output logic          done_evt,
    output logic          err_evt
);
    mv_state_t     state;
    logic [AW-1:0] sptr, dptr;
    logic [SW-1:0] rem;
    logic [2:0]    off;
    logic [31:0]   hold, hold_rd;
    logic [1:0]    sw_q, dw_q;
    logic          sfix_q, dfix_q;
    logic [2:0]    sb, db, ub;

    // Beat sizes of both sides and of one transfer unit.
    always_comb begin
        sb = beat_bytes(sw_q);
        db = beat_bytes(dw_q);
        ub = (sb > db) ? sb : db;
    end

    // Memory port outputs follow the current phase.
    always_comb begin
        mem_req   = (state != MV_IDLE);
        mem_we    = (state == MV_WRITE);
        mem_addr  = (state == MV_WRITE) ? dptr : sptr;
        mem_size  = (state == MV_WRITE) ? dw_q : sw_q;
        mem_wdata = hold >> {off[1:0], 3'b000};
        busy      = (state != MV_IDLE);
    end

    // Merge the returned read beat into the holding register.
    always_comb begin
        hold_rd = hold;
        for (int i = 0; i < 4; i++) begin
            if (3'(i) < sb)
                hold_rd[{2'(off[1:0] + 2'(i)), 3'b000} +: 8] = mem_rdata[i*8 +: 8];
        end
    end

    // Sequencer state, pointers and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= MV_IDLE;
            sptr     <= '0;
            dptr     <= '0;
            rem      <= '0;
            off      <= '0;
            hold     <= '0;
            sw_q     <= '0;
            dw_q     <= '0;
            sfix_q   <= 1'b0;
            dfix_q   <= 1'b0;
            done_evt <= 1'b0;
            err_evt  <= 1'b0;
        end else begin
            done_evt <= 1'b0;
            err_evt  <= 1'b0;
            case (state)
                MV_IDLE: if (start) begin
                    sptr   <= src_addr;
                    dptr   <= dst_addr;
                    rem    <= size;
                    off    <= '0;
                    sw_q   <= src_width;
                    dw_q   <= dst_width;
                    sfix_q <= src_fixed;
                    dfix_q <= dst_fixed;
                    if (size == '0) done_evt <= 1'b1;
                    else            state    <= MV_READ;
                end
                MV_READ: if (mem_ready) begin
                    if (mem_err) begin
                        err_evt <= 1'b1;
                        state   <= MV_IDLE;
                    end else begin
                        hold <= hold_rd;
                        if (!sfix_q) sptr <= sptr + AW'(sb);
                        if (off + sb >= ub) begin
                            off   <= '0;
                            state <= MV_WRITE;
                        end else begin
                            off <= off + sb;
                        end
                    end
                end
                MV_WRITE: if (mem_ready) begin
                    if (mem_err) begin
                        err_evt <= 1'b1;
                        state   <= MV_IDLE;
                    end else begin
                        if (!dfix_q) dptr <= dptr + AW'(db);
                        if (off + db >= ub) begin
                            off <= '0;
                            if (rem <= SW'(ub)) begin
                                done_evt <= 1'b1;
                                state    <= MV_IDLE;
                            end else begin
                                rem   <= rem - SW'(ub);
                                state <= MV_READ;
                            end
                        end else begin
                            off <= off + db;
                        end
                    end
                end
                default: state <= MV_IDLE;
            endcase
        end
    end

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
    assert_one_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_evt && err_evt));
    assert_zero_size_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && size == '0) |=> (!mem_req && done_evt));
    assert_err_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && mem_err) |=> (!mem_req && err_evt));
endmodule

// File: rtl/dma_engine.sv
// Top of the block-copy DMA engine: register decode, sticky done/error
// flags and start qualification around the sequencer and interrupt section.
// Assumes software leaves the setup registers unchanged while busy.
module dma_engine
    import dma_pkg::*;
#(
    parameter int AW  = 32,
    parameter int SW  = 16,
    parameter int RAW = 13
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we,
    input  logic [RAW-1:0] reg_addr,
    input  logic [31:0]    reg_wdata,
    output logic [31:0]    reg_rdata,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [1:0]     mem_size,
    output logic [31:0]    mem_wdata,
    input  logic [31:0]    mem_rdata,
    input  logic           mem_ready,
    input  logic           mem_err,
    output logic           irq
);
    logic [AW-1:0] src_addr, dst_addr;
    side_cfg_t     src_cfg, dst_cfg;
    logic [SW-1:0] xfer_size;
    logic          dir_q, done_flag, err_flag;
    logic          busy, done_evt, err_evt, start_go, cmd_wr, clr_wr;
    logic          pend_done, pend_err, mask_done, mask_err;

    function automatic side_cfg_t cfg_from(input logic [31:0] w);
        cfg_from = '{burst: w[18:16], fixed: w[8], width: w[1:0]};
    endfunction

    function automatic logic [31:0] cfg_to(input side_cfg_t c);
        cfg_to = {13'b0, c.burst, 7'b0, c.fixed, 6'b0, c.width};
    endfunction

    // Command decode and start qualification.
    always_comb begin
        cmd_wr   = reg_we && (reg_addr == RAW'(OFF_CMD));
        clr_wr   = reg_we && (reg_addr == RAW'(OFF_IRQ_CLR));
        start_go = cmd_wr && reg_wdata[0] && !busy && !err_flag;
    end

    // Setup registers written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_addr  <= '0;
            dst_addr  <= '0;
            src_cfg   <= '0;
            dst_cfg   <= '0;
            xfer_size <= '0;
            dir_q     <= 1'b0;
        end else if (reg_we) begin
            if (reg_addr == RAW'(OFF_SRC_ADDR)) src_addr  <= reg_wdata[AW-1:0];
            if (reg_addr == RAW'(OFF_DST_ADDR)) dst_addr  <= reg_wdata[AW-1:0];
            if (reg_addr == RAW'(OFF_SRC_CFG))  src_cfg   <= cfg_from(reg_wdata);
            if (reg_addr == RAW'(OFF_DST_CFG))  dst_cfg   <= cfg_from(reg_wdata);
            if (reg_addr == RAW'(OFF_SIZE))     xfer_size <= reg_wdata[SW-1:0];
            if (reg_addr == RAW'(OFF_DIR))      dir_q     <= reg_wdata[0];
        end
    end

    // Sticky done and error flags with separate command clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_flag <= 1'b0;
            err_flag  <= 1'b0;
        end else begin
            if (done_evt)                       done_flag <= 1'b1;
            else if (cmd_wr && reg_wdata[18])   done_flag <= 1'b0;
            if (err_evt)                        err_flag  <= 1'b1;
            else if (cmd_wr && reg_wdata[16])   err_flag  <= 1'b0;
        end
    end

    dma_mover #(.AW(AW), .SW(SW)) u_mover (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_go),
        .src_addr  (src_addr),
        .dst_addr  (dst_addr),
        .src_width (src_cfg.width),
        .src_fixed (src_cfg.fixed),
        .dst_width (dst_cfg.width),
        .dst_fixed (dst_cfg.fixed),
        .size      (xfer_size),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_size  (mem_size),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ready (mem_ready),
        .mem_err   (mem_err),
        .busy      (busy),
        .done_evt  (done_evt),
        .err_evt   (err_evt)
    );

    dma_irq_ctl u_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .done_evt     (done_evt),
        .err_evt      (err_evt),
        .clr_done     (clr_wr && reg_wdata[24]),
        .clr_err      (clr_wr && reg_wdata[16]),
        .mask_we      (reg_we && (reg_addr == RAW'(OFF_IRQ_MASK))),
        .mask_done_in (reg_wdata[24]),
        .mask_err_in  (reg_wdata[16]),
        .pend_done    (pend_done),
        .pend_err     (pend_err),
        .mask_done    (mask_done),
        .mask_err     (mask_err),
        .irq          (irq)
    );

    // Register read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RAW'(OFF_SRC_ADDR): reg_rdata = 32'(src_addr);
            RAW'(OFF_DST_ADDR): reg_rdata = 32'(dst_addr);
            RAW'(OFF_SRC_CFG):  reg_rdata = cfg_to(src_cfg);
            RAW'(OFF_DST_CFG):  reg_rdata = cfg_to(dst_cfg);
            RAW'(OFF_SIZE):     reg_rdata = 32'(xfer_size);
            RAW'(OFF_STATUS):   reg_rdata = {13'b0, done_flag, busy, err_flag, 16'b0};
            RAW'(OFF_DIR):      reg_rdata = {31'b0, dir_q};
            RAW'(OFF_IRQ_MASK): reg_rdata = {7'b0, mask_done, 7'b0, mask_err, 16'b0};
            RAW'(OFF_IRQ_PEND): reg_rdata = {7'b0, pend_done, 7'b0, pend_err, 16'b0};
            RAW'(OFF_IRQ_STAT): reg_rdata = {7'b0, pend_done && !mask_done, 7'b0,
                                             pend_err && !mask_err, 16'b0};
            default:            reg_rdata = '0;
        endcase
    end

    assert_busy_after_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_go && xfer_size != '0) |=> busy);
    assert_err_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> !busy);
    assert_done_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |=> done_flag);
endmodule

// File: tb/dma_engine_tb.sv
// Directed bench for dma_engine: one task per scenario, byte memory model
// with adjustable latency and one error-injection address.
module dma_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [12:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [1:0]  mem_size;
    logic [31:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic        mem_err = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    int lat = 1;
    int wcnt = 0;
    int err_addr = -1;
    int cycles = 0;
    logic [7:0] mem [256];

    always #5 clk = ~clk;

    dma_engine u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .mem_err(mem_err), .irq(irq)
    );

    // Memory model: answers each request after lat idle cycles.
    always @(negedge clk) begin
        if (mem_ready) begin
            mem_ready = 1'b0;
            mem_err   = 1'b0;
            wcnt      = 0;
        end else if (mem_req) begin
            if (wcnt >= lat) begin
                int nb;
                nb = (mem_size == 2'd0) ? 1 : (mem_size == 2'd1) ? 2 : 4;
                mem_ready = 1'b1;
                if (int'(mem_addr) == err_addr) begin
                    mem_err = 1'b1;
                end else if (mem_we) begin
                    for (int i = 0; i < nb; i++)
                        mem[(mem_addr[7:0] + 8'(i))] = mem_wdata[i*8 +: 8];
                    wr_cnt++;
                end else begin
                    mem_rdata = '0;
                    for (int i = 0; i < nb; i++)
                        mem_rdata[i*8 +: 8] = mem[(mem_addr[7:0] + 8'(i))];
                    rd_cnt++;
                end
            end else begin
                wcnt++;
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        #1;
        reg_we = 1'b1; reg_addr = 13'(a); reg_wdata = d;
        @(negedge clk);
        #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        #2;
        reg_addr = 13'(a);
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle;
        logic [31:0] s;
        for (int n = 0; n < 3000; n++) begin
            rd('h41C, s);
            if (!s[17]) break;
        end
    endtask

    task automatic setup(input int sa, input int scfg, input int da, input int dcfg, input int sz);
        wr('h400, 32'(sa)); wr('h404, 32'(scfg));
        wr('h408, 32'(da)); wr('h40C, 32'(dcfg));
        wr('h414, 32'(sz));
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd('h41C, v);  check("R1 status after reset", v, 32'h0);
        rd('h1024, v); check("R1 mask after reset", v, 32'h0101_0000);
        rd('h1044, v); check("R10 pending after reset", v, 32'h0);
        check("R10 irq after reset", 32'(irq), 32'h0);
    endtask

    task automatic t_regs;
        logic [31:0] v;
        wr('h400, 32'h1234_5678); rd('h400, v); check("R1 source address", v, 32'h1234_5678);
        wr('h404, 32'hFFFF_FFFF); rd('h404, v); check("R2 config fields", v, 32'h0007_0103);
        wr('h40C, 32'h0004_0002); rd('h40C, v); check("R2 dest config", v, 32'h0004_0002);
        wr('h420, 32'h3);         rd('h420, v); check("R1 direction bit", v, 32'h1);
        wr('h414, 32'h10);        rd('h414, v); check("R1 byte count", v, 32'h10);
    endtask

    task automatic t_read_xfer;
        logic [31:0] v;
        int r0, w0, bad;
        for (int i = 0; i < 16; i++) mem[i] = 8'(i * 7 + 3);
        setup('h00, 'h0004_0001, 'h80, 'h0004_0002, 16);
        wr('h420, 0);
        r0 = rd_cnt; w0 = wr_cnt;
        wr('h418, 1);
        rd('h41C, v); check("R6 busy after start", v & 32'h0002_0000, 32'h0002_0000);
        wait_idle;
        rd('h41C, v); check("R6 done flag", v, 32'h0004_0000);
        bad = 0;
        for (int i = 0; i < 16; i++) if (mem['h80 + i] !== mem[i]) bad++;
        check("R3 data copied 16->32", 32'(bad), 0);
        check("R3 read beats", 32'(rd_cnt - r0), 8);
        check("R3 write beats", 32'(wr_cnt - w0), 4);
        wr('h418, 32'h0004_0000);
        rd('h41C, v); check("R6 done cleared", v, 32'h0);
    endtask

    task automatic t_write_xfer;
        int r0, w0, bad;
        for (int i = 0; i < 12; i++) mem['h20 + i] = 8'(8'hA0 ^ 8'(i * 13));
        setup('h20, 'h0004_0002, 'hA0, 'h0004_0001, 12);
        wr('h420, 1);
        r0 = rd_cnt; w0 = wr_cnt;
        wr('h418, 1);
        wait_idle;
        bad = 0;
        for (int i = 0; i < 12; i++) if (mem['hA0 + i] !== mem['h20 + i]) bad++;
        check("R4 data copied 32->16", 32'(bad), 0);
        check("R4 read beats", 32'(rd_cnt - r0), 3);
        check("R4 write beats", 32'(wr_cnt - w0), 6);
        wr('h418, 32'h0004_0000);
    endtask

    task automatic t_fixed;
        int r0, bad;
        mem['h40] = 8'h11; mem['h41] = 8'h22; mem['h42] = 8'h33; mem['h43] = 8'h44;
        setup('h40, 'h0004_0101, 'hC0, 'h0004_0002, 8);
        r0 = rd_cnt;
        wr('h418, 1);
        wait_idle;
        bad = 0;
        for (int i = 0; i < 8; i++)
            if (mem['hC0 + i] !== ((i % 2 == 0) ? 8'h11 : 8'h22)) bad++;
        check("R5 fixed source address", 32'(bad), 0);
        check("R5 read beats", 32'(rd_cnt - r0), 4);
        wr('h418, 32'h0004_0000);
    endtask

    task automatic t_zero;
        logic [31:0] v;
        int r0, w0;
        setup('h00, 'h1, 'h80, 'h2, 0);
        r0 = rd_cnt; w0 = wr_cnt;
        wr('h418, 1);
        repeat (4) @(negedge clk);
        rd('h41C, v); check("R7 zero count sets done", v, 32'h0004_0000);
        check("R7 no memory access", 32'(rd_cnt - r0 + wr_cnt - w0), 0);
        wr('h418, 32'h0004_0000);
    endtask

    task automatic t_busy;
        logic [31:0] v;
        int r0;
        lat = 6;
        setup('h00, 'h0004_0001, 'h80, 'h0004_0002, 16);
        r0 = rd_cnt;
        wr('h418, 1);
        repeat (5) @(negedge clk);
        wr('h418, 1);
        wait_idle;
        repeat (5) @(negedge clk);
        rd('h41C, v); check("R9 restart ignored, idle", v, 32'h0004_0000);
        check("R9 single transfer reads", 32'(rd_cnt - r0), 8);
        lat = 1;
        wr('h418, 32'h0004_0000);
    endtask

    task automatic t_error;
        logic [31:0] v;
        int r0, w0;
        setup('h00, 'h0004_0001, 'hE0, 'h0004_0002, 16);
        err_addr = 'h04;
        r0 = rd_cnt; w0 = wr_cnt;
        wr('h418, 1);
        wait_idle;
        rd('h41C, v); check("R8 error flag, not busy", v, 32'h0001_0000);
        check("R8 reads before error", 32'(rd_cnt - r0), 2);
        check("R8 writes before error", 32'(wr_cnt - w0), 1);
        err_addr = -1;
        r0 = rd_cnt;
        wr('h418, 1);
        repeat (6) @(negedge clk);
        check("R8 start ignored while error", 32'(rd_cnt - r0), 0);
        rd('h1044, v); check("R10 error pending bit", v & 32'h0001_0000, 32'h0001_0000);
        wr('h418, 32'h0001_0000);
        rd('h41C, v); check("R8 error cleared", v, 32'h0);
        wr('h418, 1);
        wait_idle;
        rd('h41C, v); check("R8 start works after clear", v, 32'h0004_0000);
        wr('h418, 32'h0004_0000);
    endtask

    task automatic t_irq;
        logic [31:0] v;
        wr('h1004, 32'h0101_0000);
        rd('h1044, v); check("R11 pending cleared", v, 32'h0);
        setup('h00, 'h1, 'h80, 'h2, 0);
        wr('h418, 1);
        repeat (3) @(negedge clk);
        rd('h1044, v); check("R10 done pending", v, 32'h0100_0000);
        rd('h1064, v); check("R10 masked status blocked", v, 32'h0);
        check("R10 irq masked", 32'(irq), 0);
        wr('h1024, 32'h0001_0000);
        rd('h1064, v); check("R10 masked status open", v, 32'h0100_0000);
        check("R10 irq raised", 32'(irq), 1);
        wr('h1004, 32'h0100_0000);
        rd('h1044, v); check("R11 done pending cleared", v, 32'h0);
        check("R11 irq dropped", 32'(irq), 0);
        wr('h418, 32'h0004_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_regs;
        t_read_xfer;
        t_write_xfer;
        t_fixed;
        t_zero;
        t_busy;
        t_error;
        t_irq;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule